// File: doc/BRIEF.md
# Prescaled Periodic Interrupt Timer

This block is a memory-mapped up-counting timer that raises a periodic interrupt request. A programmable prescaler divides the clock; each prescaler overflow advances a main counter by one. When the counter reaches the programmed reload value on an advancing tick, it returns to zero and raises a sticky update flag. The interrupt line is a level signal that is high while that flag is set and the interrupt enable is on. Software picks the interrupt period by choosing the divider and reload values. It acknowledges an interrupt by writing zero to the flag.

The register port is a single-cycle bus with a select, a write strobe, a byte address and data. Writes take effect on the clock edge. Reads return the addressed register in the same cycle. The register layout is CTRL at 0x00 (bit 0 run), IEN at 0x04 (bit 0 update interrupt enable), STAT at 0x08 (bit 0 update flag), COUNT at 0x0C, DIV at 0x10 (divider, clock divided by DIV+1) and TOP at 0x14 (reload value).

Top module: `pit_timer`

## Requirements
- R1: After a synchronous active-low reset, CTRL, IEN, STAT, COUNT and DIV read 0, TOP reads all ones over CNT_W bits, and irq is low.
- R2: While CTRL bit 0 is 1 and DIV holds D, the counter advances once every D+1 clocks. The prescaler phase restarts when it is at or above D, so lowering DIV never causes a long run-away.
- R3: On an advancing tick, a counter that is equal to or above TOP returns to 0. Otherwise it increments by one.
- R4: While CTRL bit 0 is 0, the counter and the prescaler phase hold their values.
- R5: STAT bit 0 becomes 1 on the clock edge where the counter returns to 0 on a tick, and it stays 1 until software clears it.
- R6: Writing STAT with bit 0 = 0 clears the flag. Writing it with bit 0 = 1 leaves the flag unchanged.
- R7: If a wrap and a clearing write to STAT fall in the same cycle, the flag ends up 1.
- R8: irq is high exactly when STAT bit 0 and IEN bit 0 are both 1, as a level.
- R9: A write to COUNT loads the low CNT_W bits of the data on the next edge, and it takes precedence over an advance in that cycle.
- R10: Only bit 0 of CTRL, IEN and STAT is stored, and their other bits read 0. DIV and TOP store their low PSC_W and CNT_W bits. Unmapped addresses read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data of the addressed register, same cycle |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the timer with an 8-bit counter and a 4-bit divider. With these widths, the all-ones reload value after reset and a count loaded above the reload value are both reachable within a few hundred cycles. Setting the divider to 0 and the reload value to 0 makes every enabled cycle a wrap. This lets the bench land a clearing write on a wrap edge and check that the set wins. A behavioural model tracks the divider phase, the count and the flag every clock and compares irq and every read against them.

// File: rtl/pit_pkg.sv
// pit_pkg: register offsets and field positions shared by the timer modules.
// Assumes byte addressing; offsets fit in any ADDR_W of 5 or more.
package pit_pkg;
    localparam int OFS_CTRL  = 'h00;
    localparam int OFS_IEN   = 'h04;
    localparam int OFS_STAT  = 'h08;
    localparam int OFS_COUNT = 'h0C;
    localparam int OFS_DIV   = 'h10;
    localparam int OFS_TOP   = 'h14;
    localparam int BIT_RUN   = 0;
    localparam int BIT_UIE   = 0;
    localparam int BIT_UPD   = 0;
endpackage

// File: rtl/pit_prescaler.sv
// pit_prescaler: divides the clock by limit+1 while run is high.
// Emits a one-cycle tick in the cycle where the phase is at or above limit.
// Assumes limit may change at any time; a phase above it restarts at once.
module pit_prescaler #(
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PSC_W-1:0] limit,
    output logic             tick
);
    logic [PSC_W-1:0] phase_q;

    // tick when running and the phase has reached the divider value
    always_comb tick = run && (phase_q >= limit);

    // advance or restart the phase; hold it while stopped
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= '0;
        else if (tick)
            phase_q <= '0;
        else if (run)
            phase_q <= phase_q + 1'b1;
    end

    AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> phase_q == '0); // R2
    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(phase_q)); // R4
endmodule

// File: rtl/pit_counter.sv
// pit_counter: main up-counter advanced by prescaler ticks.
// Returns to zero when at or above top on a tick and reports that as wrap.
// A software load takes precedence over the advance in the same cycle.
module pit_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] top,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    logic [CNT_W-1:0] count_q;

    // wrap event: advancing tick while at or past the reload value
    always_comb wrap = tick && (count_q >= top);

    // load, wrap, increment or hold the count
    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= '0;
        else if (load)
            count_q <= load_val;
        else if (wrap)
            count_q <= '0;
        else if (tick)
            count_q <= count_q + 1'b1;
    end

    assign count = count_q;

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !load) |=> count_q == '0); // R3
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(count_q)); // R4
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> count_q == $past(load_val)); // R9
endmodule

// File: rtl/pit_regs.sv
// pit_regs: register file, address decode, update flag and interrupt level.
// Assumes DATA_W >= CNT_W and DATA_W >= PSC_W; reads are combinational.
module pit_regs
    import pit_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6,
    parameter int CNT_W  = 16,
    parameter int PSC_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              wrap,
    output logic              run,
    output logic [PSC_W-1:0]  div,
    output logic [CNT_W-1:0]  top,
    output logic              cnt_load,
    output logic [CNT_W-1:0]  cnt_load_val,
    output logic              irq
);
    logic run_q, uie_q, flag_q;
    logic [PSC_W-1:0] div_q;
    logic [CNT_W-1:0] top_q;
    logic wr_ctrl, wr_ien, wr_stat, wr_count, wr_div, wr_top;

    // address decode for writes
    always_comb begin
        wr_ctrl  = bus_sel && bus_we && (bus_addr == ADDR_W'(OFS_CTRL));
        wr_ien   = bus_sel && bus_we && (bus_addr == ADDR_W'(OFS_IEN));
        wr_stat  = bus_sel && bus_we && (bus_addr == ADDR_W'(OFS_STAT));
        wr_count = bus_sel && bus_we && (bus_addr == ADDR_W'(OFS_COUNT));
        wr_div   = bus_sel && bus_we && (bus_addr == ADDR_W'(OFS_DIV));
        wr_top   = bus_sel && bus_we && (bus_addr == ADDR_W'(OFS_TOP));
    end

    // control and interrupt-enable bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            uie_q <= 1'b0;
        end else begin
            if (wr_ctrl) run_q <= bus_wdata[BIT_RUN];
            if (wr_ien)  uie_q <= bus_wdata[BIT_UIE];
        end
    end

    // sticky update flag: wrap sets, written zero clears, set wins
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (wrap)
            flag_q <= 1'b1;
        else if (wr_stat && !bus_wdata[BIT_UPD])
            flag_q <= 1'b0;
    end

    // divider and reload values
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            top_q <= '1;
        end else begin
            if (wr_div) div_q <= bus_wdata[PSC_W-1:0];
            if (wr_top) top_q <= bus_wdata[CNT_W-1:0];
        end
    end

    // read multiplexer; unmapped addresses read zero
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_we) begin
            case (int'(bus_addr))
                OFS_CTRL:  bus_rdata[BIT_RUN] = run_q;
                OFS_IEN:   bus_rdata[BIT_UIE] = uie_q;
                OFS_STAT:  bus_rdata[BIT_UPD] = flag_q;
                OFS_COUNT: bus_rdata = DATA_W'(count);
                OFS_DIV:   bus_rdata = DATA_W'(div_q);
                OFS_TOP:   bus_rdata = DATA_W'(top_q);
                default:   bus_rdata = '0;
            endcase
        end
    end

    // outputs towards the counting path and the interrupt line
    always_comb begin
        run          = run_q;
        div          = div_q;
        top          = top_q;
        cnt_load     = wr_count;
        cnt_load_val = bus_wdata[CNT_W-1:0];
        irq          = flag_q && uie_q;
    end

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> flag_q); // R7
    AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(wrap)); // R5
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && !bus_wdata[BIT_UPD] && !wrap) |=> !flag_q); // R6
    AST_IRQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!wrap && !flag_q) |=> !irq); // R8
endmodule

// File: rtl/pit_timer.sv
// pit_timer: top of the prescaled periodic interrupt timer.
// Connects the register file, prescaler and counter; no logic of its own.
module pit_timer #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6,
    parameter int CNT_W  = 16,
    parameter int PSC_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic             run, tick, wrap, cnt_load;
    logic [PSC_W-1:0] div;
    logic [CNT_W-1:0] top, count, cnt_load_val;

    pit_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PSC_W(PSC_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .count(count), .wrap(wrap), .run(run), .div(div), .top(top),
        .cnt_load(cnt_load), .cnt_load_val(cnt_load_val), .irq(irq)
    );

    pit_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk(clk), .rst_n(rst_n), .run(run), .limit(div), .tick(tick)
    );

    pit_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .top(top),
        .load(cnt_load), .load_val(cnt_load_val), .count(count), .wrap(wrap)
    );
endmodule

// File: tb/pit_timer_test.sv
module pit_timer_test;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 6;
    localparam int CNT_W  = 8;
    localparam int PSC_W  = 4;
    localparam int CMASK  = (1 << CNT_W) - 1;
    localparam int PMASK  = (1 << PSC_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              irq;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    // behavioural reference state
    int m_run, m_uie, m_flag, m_cnt, m_phase, m_div, m_top;

    pit_timer #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PSC_W(PSC_W)) uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #10 clk = ~clk; // 50 MHz

    // reference model, one step per rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_uie = 0; m_flag = 0; m_cnt = 0; m_phase = 0;
            m_div = 0; m_top = CMASK;
        end else begin
            int a, d, tick, wrapped, ncnt, nphase;
            a = int'(bus_addr);
            d = int'(bus_wdata);
            tick = (m_run != 0) && (m_phase >= m_div);
            nphase = tick ? 0 : (m_run != 0 ? m_phase + 1 : m_phase);
            wrapped = tick && (m_cnt >= m_top);
            ncnt = m_cnt;
            if (tick) ncnt = wrapped ? 0 : m_cnt + 1;
            if (bus_sel && bus_we) begin
                if (a == 'h00) m_run = d & 1;
                if (a == 'h04) m_uie = d & 1;
                if (a == 'h08 && (d & 1) == 0 && !wrapped) m_flag = 0;
                if (a == 'h0C) ncnt = d & CMASK;
                if (a == 'h10) m_div = d & PMASK;
                if (a == 'h14) m_top = d & CMASK;
            end
            if (wrapped) m_flag = 1;
            m_cnt = ncnt;
            m_phase = nphase;
        end
    end

    function automatic int expect_read(int a);
        case (a)
            'h00: return m_run;
            'h04: return m_uie;
            'h08: return m_flag;
            'h0C: return m_cnt;
            'h10: return m_div;
            'h14: return m_top;
            default: return 0;
        endcase
    endfunction

    function automatic string tag_of(int a);
        case (a)
            'h08: return "R5";
            'h0C: return "R2";
            default: return "R10";
        endcase
    endfunction

    // compare every cycle, a quarter period after the edge
    always @(posedge clk) begin
        #5;
        if (!done) begin
            vectors++;
            if (int'(irq) != ((m_flag != 0 && m_uie != 0) ? 1 : 0)) begin
                fails++;
                $display("FAIL R8 irq: actual %0d expected %0d", irq, (m_flag & m_uie));
            end
            if (bus_sel && !bus_we) begin
                vectors++;
                if (int'(bus_rdata) != expect_read(int'(bus_addr))) begin
                    fails++;
                    $display("FAIL %s read 0x%0h: actual 0x%0h expected 0x%0h",
                             tag_of(int'(bus_addr)), bus_addr, bus_rdata,
                             expect_read(int'(bus_addr)));
                end
            end
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = DATA_W'(d);
    endtask

    task automatic rd(input int a, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bus_sel = 1'b1; bus_we = 1'b0; bus_addr = ADDR_W'(a); bus_wdata = '0;
        end
    endtask

    initial begin
        // R1: reset values of every register
        rd('h00, 1); rd('h04, 1); rd('h08, 1);
        @(negedge clk); rst_n = 1'b1;
        rd('h0C, 1); rd('h10, 1); rd('h14, 1); rd('h08, 1);
        // R2 R3 R5 R8: divide by 3, wrap after 5, interrupt enabled
        wr('h14, 5); wr('h10, 2); wr('h04, 1); wr('h00, 1);
        rd('h0C, 60); rd('h08, 2);
        // R6: writing one keeps the flag, writing zero clears it
        wr('h08, 1); rd('h08, 2);
        wr('h08, 0); rd('h08, 3); rd('h0C, 10);
        // R4: stopped counter and prescaler hold
        wr('h00, 0); rd('h0C, 12); rd('h08, 1);
        wr('h00, 1); rd('h0C, 4);
        // R9: load while running; R3: loaded above reload wraps next tick
        wr('h0C, 3); rd('h0C, 5);
        wr('h0C, 200); rd('h0C, 8); rd('h08, 1);
        // R2: lower the divider while the phase is above it
        wr('h10, 9); rd('h0C, 6); wr('h10, 1); rd('h0C, 10);
        // R8: enable off masks irq while flag is set
        wr('h04, 0); rd('h08, 10); wr('h04, 1); rd('h08, 2);
        // R7: every cycle wraps; a clearing write loses to the set
        wr('h10, 0); wr('h14, 0); rd('h0C, 3);
        wr('h08, 0); rd('h08, 3);
        // R1 path again: all-ones reload reachable with full count
        wr('h14, CMASK); wr('h0C, CMASK - 2); rd('h0C, 6);
        // R10: upper bits ignored, unmapped reads zero, unmapped write ignored
        wr('h00, 'hFFFF_FFFE); rd('h00, 1); rd('h0C, 3);
        wr('h3C, 'h1234); rd('h3C, 1); rd('h20, 1);
        wr('h10, 'hFFF3); rd('h10, 1);
        wr('h14, 'h1_0107); rd('h14, 1); rd('h04, 1);
        @(negedge clk); bus_sel = 1'b0;
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    // watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule